// File: doc/BRIEF.md
# Directory Invalidation Acknowledgement Collector

This block sits beside a coherence directory in a write-back, invalidation-based system built on a general interconnect. It accepts a write or synchronization request for a tracked line, together with that line's sharer vector. It grants the line to the requester at once. In the same cycle it sends invalidations to every other cache holding a copy.

The block then counts the acknowledgements that come back for that line. When the last one arrives, it sends one completion acknowledgement to the writer. That acknowledgement tells the writer that its write is now visible everywhere. If the requester is the only sharer, the completion is sent together with the grant. If the line is held exclusive elsewhere, the grant alone marks completion.

A line whose acknowledgements are still outstanding refuses new requests until it drains. Several lines can each have a collection in progress at the same time.

Top module: `invAckCollector`

## Requirements
- R1: After reset, grantValid, invValid and doneValid are low, and reqReady is high while no acknowledgement is arriving.
- R2: A request accepted at a clock edge (reqValid and reqReady both high) produces grantValid high for exactly the next cycle, with grantLine equal to the request line and grantDst equal to the request source.
- R3: An accepted request that is not exclusive and has at least one sharer other than the requester raises invValid in the same cycle as its grant. invMask equals the sharer vector with the requester's bit cleared, where bit k stands for cache k.
- R4: The pending count of a line is loaded with the number of bits set in invMask. Each acknowledgement to that line lowers the count by one. The acknowledgement that brings it to zero is followed one cycle later by doneValid, with doneLine equal to that line and doneDst equal to the original writer.
- R5: An acknowledgement to a line whose pending count is zero has no effect: no done and no change to any count.
- R6: An accepted non-exclusive request with no sharer other than the requester raises doneValid in the same cycle as its grant, addressed to the requester, with no invalidation.
- R7: An accepted request with reqExcl high produces a grant only. It produces no invalidation and no done, whatever the sharer vector holds.
- R8: While a line's pending count is nonzero, reqReady is low for requests to that line, and the count is never reloaded before it reaches zero.
- R9: reqSync has no effect on any output. A synchronization request is handled exactly like a write.
- R10: reqReady is low in any cycle in which an arriving acknowledgement brings some line's count to zero.
- R11: Different lines keep independent counts and writers, so collections on several lines can overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqLine | input | LINE_W | Index of the tracked line |
| reqSrc | input | SRC_W | Requesting cache |
| reqSync | input | 1 | Request is a synchronization operation |
| reqExcl | input | 1 | Line is currently exclusive in some cache |
| reqSharers | input | NUM_CACHES | Sharer vector of the line, one bit per cache |
| reqReady | output | 1 | Request can be accepted this cycle |
| ackValid | input | 1 | Invalidation acknowledgement present |
| ackLine | input | LINE_W | Line the acknowledgement refers to |
| grantValid | output | 1 | Line grant to the writer |
| grantLine | output | LINE_W | Granted line |
| grantDst | output | SRC_W | Cache receiving the grant |
| invValid | output | 1 | Invalidation round issued |
| invLine | output | LINE_W | Line being invalidated |
| invMask | output | NUM_CACHES | Caches that must invalidate |
| doneValid | output | 1 | Completion acknowledgement |
| doneLine | output | LINE_W | Line whose write completed |
| doneDst | output | SRC_W | Writer receiving the completion |

## Verification
A count loaded with the wrong value, or decremented on the wrong line, shows up at the ports. Either doneValid arrives one or more acknowledgements early or late, or it never arrives and the line keeps reqReady low for good. A corrupted writer register appears as a wrong doneDst in the cycle after the last acknowledgement. A wrong mask is visible in invMask in the cycle after acceptance. Every cycle of the bench compares reqReady and all three output groups with a reference model, so such faults are seen in the cycle where they first matter.

// File: rtl/invColPkg.sv
package invColPkg;
  // strobes from control to datapath, one cycle of decisions
  typedef struct packed {
    logic take;       // request accepted
    logic sendInv;    // accepted with other sharers: start a collection
    logic quickDone;  // accepted with no other sharer: complete at once
    logic ackHit;     // acknowledgement to a line with pending count
    logic ackLast;    // that acknowledgement drains the line
  } ctlStrobes_t;
endpackage

// File: rtl/invColControl.sv
module invColControl
  import invColPkg::*;
(
  input  logic        reqValid,
  input  logic        reqExcl,
  input  logic        reqLineBusy,
  input  logic        ackValid,
  input  logic        ackLineBusy,
  input  logic        ackCntOne,
  input  logic        otherZero,
  output logic        reqReady,
  output ctlStrobes_t strobes
);
  always_comb begin
    strobes.ackHit    = ackValid && ackLineBusy;
    strobes.ackLast   = strobes.ackHit && ackCntOne;
    // one done per cycle: a draining acknowledgement blocks new requests
    reqReady          = !reqLineBusy && !strobes.ackLast;
    strobes.take      = reqValid && reqReady;
    strobes.sendInv   = strobes.take && !reqExcl && !otherZero;
    strobes.quickDone = strobes.take && !reqExcl && otherZero;
  end
endmodule

// File: rtl/invColDatapath.sv
module invColDatapath
  import invColPkg::*;
#(
  parameter int NUM_CACHES = 8,
  parameter int LINE_W     = 2,
  localparam int NUM_LINES = 1 << LINE_W,
  localparam int SRC_W     = $clog2(NUM_CACHES),
  localparam int CNT_W     = $clog2(NUM_CACHES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strobes,
  input  logic [LINE_W-1:0]     reqLine,
  input  logic [SRC_W-1:0]      reqSrc,
  input  logic [NUM_CACHES-1:0] reqSharers,
  input  logic [LINE_W-1:0]     ackLine,
  output logic                  reqLineBusy,
  output logic                  ackLineBusy,
  output logic                  ackCntOne,
  output logic                  otherZero,
  output logic                  grantValid,
  output logic [LINE_W-1:0]     grantLine,
  output logic [SRC_W-1:0]      grantDst,
  output logic                  invValid,
  output logic [LINE_W-1:0]     invLine,
  output logic [NUM_CACHES-1:0] invMask,
  output logic                  doneValid,
  output logic [LINE_W-1:0]     doneLine,
  output logic [SRC_W-1:0]      doneDst
);
  logic [NUM_CACHES-1:0] selfBit;
  logic [NUM_CACHES-1:0] invTargets;
  logic [CNT_W-1:0]      otherCnt;
  logic [CNT_W-1:0]      lineCnt   [NUM_LINES];
  logic [SRC_W-1:0]      lineOwner [NUM_LINES];
  logic [NUM_LINES-1:0]  lineBusy;

  always_comb begin
    selfBit = '0;
    selfBit[reqSrc] = 1'b1;
    invTargets = reqSharers & ~selfBit;
    otherCnt = '0;
    for (int k = 0; k < NUM_CACHES; k++) otherCnt = otherCnt + CNT_W'(invTargets[k]);
  end

  assign otherZero   = (otherCnt == '0);
  assign reqLineBusy = lineBusy[reqLine];
  assign ackLineBusy = lineBusy[ackLine];
  assign ackCntOne   = (lineCnt[ackLine] == CNT_W'(1));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign lineBusy[i] = (lineCnt[i] != '0);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineCnt[i]   <= '0;
        lineOwner[i] <= '0;
      end else if (strobes.sendInv && reqLine == LINE_W'(i)) begin
        lineCnt[i]   <= otherCnt;
        lineOwner[i] <= reqSrc;
      end else if (strobes.ackHit && ackLine == LINE_W'(i)) begin
        lineCnt[i]   <= lineCnt[i] - CNT_W'(1);
      end
    end

    // a pending count only holds or steps down by one
    p_no_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
      ($past(lineCnt[i]) != '0) |->
        (lineCnt[i] == $past(lineCnt[i]) || lineCnt[i] == $past(lineCnt[i]) - CNT_W'(1)))
      else $error("pending count of a line reloaded or skipped");
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantLine  <= '0;
      grantDst   <= '0;
      invValid   <= 1'b0;
      invLine    <= '0;
      invMask    <= '0;
      doneValid  <= 1'b0;
      doneLine   <= '0;
      doneDst    <= '0;
    end else begin
      grantValid <= strobes.take;
      invValid   <= strobes.sendInv;
      doneValid  <= strobes.quickDone || strobes.ackLast;
      if (strobes.take) begin
        grantLine <= reqLine;
        grantDst  <= reqSrc;
      end
      if (strobes.sendInv) begin
        invLine <= reqLine;
        invMask <= invTargets;
      end
      if (strobes.quickDone) begin
        doneLine <= reqLine;
        doneDst  <= reqSrc;
      end else if (strobes.ackLast) begin
        doneLine <= ackLine;
        doneDst  <= lineOwner[ackLine];
      end
    end
  end

  p_inv_with_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (grantValid && invLine == grantLine))
    else $error("invalidation without matching grant");

  p_inv_skips_writer_r3: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (invMask[grantDst] == 1'b0 && invMask != '0))
    else $error("invalidation mask targets writer or nobody");

  p_done_drained_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (lineCnt[doneLine] == '0))
    else $error("completion sent with acknowledgements outstanding");
endmodule

// File: rtl/invAckCollector.sv
module invAckCollector
  import invColPkg::*;
#(
  parameter int NUM_CACHES = 8,
  parameter int LINE_W     = 2,
  localparam int SRC_W     = $clog2(NUM_CACHES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [LINE_W-1:0]     reqLine,
  input  logic [SRC_W-1:0]      reqSrc,
  input  logic                  reqSync,
  input  logic                  reqExcl,
  input  logic [NUM_CACHES-1:0] reqSharers,
  output logic                  reqReady,
  input  logic                  ackValid,
  input  logic [LINE_W-1:0]     ackLine,
  output logic                  grantValid,
  output logic [LINE_W-1:0]     grantLine,
  output logic [SRC_W-1:0]      grantDst,
  output logic                  invValid,
  output logic [LINE_W-1:0]     invLine,
  output logic [NUM_CACHES-1:0] invMask,
  output logic                  doneValid,
  output logic [LINE_W-1:0]     doneLine,
  output logic [SRC_W-1:0]      doneDst
);
  ctlStrobes_t strobes;
  logic reqLineBusy, ackLineBusy, ackCntOne, otherZero;

  invColControl u_ctl (
    .reqValid   (reqValid),
    .reqExcl    (reqExcl),
    .reqLineBusy(reqLineBusy),
    .ackValid   (ackValid),
    .ackLineBusy(ackLineBusy),
    .ackCntOne  (ackCntOne),
    .otherZero  (otherZero),
    .reqReady   (reqReady),
    .strobes    (strobes)
  );

  invColDatapath #(.NUM_CACHES(NUM_CACHES), .LINE_W(LINE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqLine    (reqLine),
    .reqSrc     (reqSrc),
    .reqSharers (reqSharers),
    .ackLine    (ackLine),
    .reqLineBusy(reqLineBusy),
    .ackLineBusy(ackLineBusy),
    .ackCntOne  (ackCntOne),
    .otherZero  (otherZero),
    .grantValid (grantValid),
    .grantLine  (grantLine),
    .grantDst   (grantDst),
    .invValid   (invValid),
    .invLine    (invLine),
    .invMask    (invMask),
    .doneValid  (doneValid),
    .doneLine   (doneLine),
    .doneDst    (doneDst)
  );

  // a synchronization request is accepted and granted like any write
  p_sync_like_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSync && reqReady) |=> (grantValid && grantLine == $past(reqLine)))
    else $error("synchronization request not granted like a write");
endmodule

// File: tb/invAckCollector_test.sv
`timescale 1ns/1ps
module invAckCollector_test;
  localparam int NC = 8;
  localparam int LW = 2;
  localparam int NL = 1 << LW;
  localparam int SW = $clog2(NC);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqSync = 1'b0, reqExcl = 1'b0, ackValid = 1'b0;
  logic [LW-1:0] reqLine = '0, ackLine = '0;
  logic [SW-1:0] reqSrc = '0;
  logic [NC-1:0] reqSharers = '0;
  logic reqReady, grantValid, invValid, doneValid;
  logic [LW-1:0] grantLine, invLine, doneLine;
  logic [SW-1:0] grantDst, doneDst;
  logic [NC-1:0] invMask;

  int checks = 0;
  int fails = 0;
  int mCnt [NL];
  int mOwn [NL];

  always #2 clk = ~clk;

  invAckCollector #(.NUM_CACHES(NC), .LINE_W(LW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLine(reqLine), .reqSrc(reqSrc),
    .reqSync(reqSync), .reqExcl(reqExcl), .reqSharers(reqSharers), .reqReady(reqReady),
    .ackValid(ackValid), .ackLine(ackLine), .grantValid(grantValid), .grantLine(grantLine),
    .grantDst(grantDst), .invValid(invValid), .invLine(invLine), .invMask(invMask),
    .doneValid(doneValid), .doneLine(doneLine), .doneDst(doneDst)
  );

  function automatic int popc(input int v);
    int n = 0;
    for (int k = 0; k < NC; k++) n += (v >> k) & 1;
    return n;
  endfunction

  task automatic chk(input string tag, input string note, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, note, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, predict, check after the rising edge
  task automatic cyc(input bit rv, input int ln, input int src, input bit sy, input bit ex,
                     input int shr, input bit av, input int al, input string note);
    bit aLast, rdy, tk, eInv, eQuick, eDone;
    int mask, oc, eDst, eDLine;
    string dTag;
    reqValid = rv; reqLine = LW'(ln); reqSrc = SW'(src); reqSync = sy; reqExcl = ex;
    reqSharers = NC'(shr); ackValid = av; ackLine = LW'(al);
    #1;
    aLast = av && mCnt[al] == 1;
    rdy = (mCnt[ln] == 0) && !aLast;
    chk((aLast && mCnt[ln] == 0) ? "R10" : "R8", note, int'(reqReady), int'(rdy));
    tk = rv && rdy;
    mask = shr & ~(1 << src) & ((1 << NC) - 1);
    oc = popc(mask);
    eInv = tk && !ex && oc != 0;
    eQuick = tk && !ex && oc == 0;
    eDone = eQuick || aLast;
    eDst = eQuick ? src : mOwn[al];
    eDLine = eQuick ? ln : al;
    dTag = aLast ? "R4" : eQuick ? "R6" : (tk && ex) ? "R7" : (av && mCnt[al] == 0) ? "R5" : "R4";
    @(posedge clk); #1;
    chk("R2", note, int'(grantValid), int'(tk));
    if (tk) begin
      chk("R2", note, int'(grantLine), ln);
      chk("R2", note, int'(grantDst), src);
    end
    chk((tk && ex) ? "R7" : "R3", note, int'(invValid), int'(eInv));
    if (eInv) begin
      chk("R3", note, int'(invMask), mask);
      chk("R3", note, int'(invLine), ln);
    end
    chk(dTag, note, int'(doneValid), int'(eDone));
    if (eDone) begin
      chk(dTag, note, int'(doneLine), eDLine);
      chk(dTag, note, int'(doneDst), eDst);
    end
    if (av && mCnt[al] > 0) mCnt[al]--;
    if (eInv) begin
      mCnt[ln] = oc;
      mOwn[ln] = src;
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin mCnt[i] = 0; mOwn[i] = 0; end
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "reset grant", int'(grantValid), 0);
    chk("R1", "reset inv", int'(invValid), 0);
    chk("R1", "reset done", int'(doneValid), 0);
    chk("R1", "reset ready", int'(reqReady), 1);
    @(negedge clk);

    // directed corner cases
    cyc(1, 0, 2, 0, 0, 'h16, 0, 0, "R2 two others");
    cyc(0, 0, 0, 0, 0, 0, 1, 1, "R5 ack to idle line");
    cyc(1, 0, 5, 0, 0, 'hFF, 0, 0, "R8 stall busy line");
    cyc(1, 1, 0, 1, 0, 'h01, 0, 0, "R9 R11 sync sole sharer");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, "R4 first ack");
    cyc(1, 2, 1, 0, 0, 'h0F, 1, 0, "R10 last ack blocks request");
    cyc(1, 3, 4, 0, 1, 'hFF, 0, 0, "R7 exclusive grant only");
    cyc(1, 2, 1, 1, 0, 'h0F, 0, 0, "R9 sync same as write");
    cyc(1, 3, 6, 0, 0, 'hC0, 1, 2, "R11 second line overlaps");

    // random traffic against the reference model
    for (int n = 0; n < 4000; n++) begin
      cyc(($urandom % 2) == 0, $urandom % NL, $urandom % NC, ($urandom % 4) == 0,
          ($urandom % 6) == 0, $urandom % 256, ($urandom % 10) < 7, $urandom % NL, "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule